// File: doc/BRIEF.md
# Interleaved Two-Lane Streaming Accumulator

This block adds up a burst of samples that arrive one per clock with no gaps, built from adders that each take two cycles to produce a result. An adder whose output is fed back to its own input can absorb a new sample only every second cycle. The block therefore gives each sample a lane according to its position in the burst. Positions 0, 2, 4 and so on go to lane 0, and positions 1, 3, 5 and so on go to lane 1. Each lane keeps a running partial sum in its own feedback loop, so that loop takes a new sample only every second cycle.

When the valid strobe drops, the burst is over. A third adder then adds the two partial sums and presents the total for one cycle, marked by a done pulse. The lane that took the last sample gives its result one cycle later than the other lane. A one-cycle held copy of each lane's output lines the two partial sums up for the final adder. There are three adder instances in all. Every sum wraps modulo 2^DATA_WIDTH.

Top module: `interleaved_accumulator`

## Requirements
- R1: While the active-low asynchronous reset `rstN` is low, and after it is released with no burst applied, `totalDone` is 0 and `totalOut` is 0.
- R2: For a burst of N ≥ 2 consecutive cycles with `sampleValid` high, `totalOut` equals the sum of all N samples modulo 2^DATA_WIDTH in the cycle that `totalDone` is high.
- R3: `totalDone` is high for exactly one cycle per burst. It becomes visible right after the third rising edge that follows the edge capturing the burst's last sample. It is low in every other cycle.
- R4: `totalOut` is 0 in every cycle in which `totalDone` is low.
- R5: A burst of a single sample (N = 1) produces a total equal to that sample. Lane 1 contributes zero in that case.
- R6: Each burst is summed from zero. Bursts separated by a single idle cycle each produce their own total, and no value carries over from the earlier burst.
- R7: Sums wrap modulo 2^DATA_WIDTH. With DATA_WIDTH = 8, the samples 0xFF, 0x02 give 0x01, and sixteen samples of 0xFF give 0xF0.
- R8: `sampleIn` is ignored in cycles where `sampleValid` is low. Arbitrary data on idle cycles does not change any total.
- R9: Every adder instance gives its result exactly two cycles after its operands. The sample at burst position 0 enters lane 0 with a cleared partial sum. At most one lane loads a sample in any cycle.
- R10: Asserting reset in the middle of a burst discards that burst: no done pulse follows for it, and the next burst after reset is summed correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleIn | input | DATA_WIDTH | Sample value, read when `sampleValid` is high |
| sampleValid | input | 1 | High for each cycle of a gap-free burst |
| totalOut | output | DATA_WIDTH | Burst total while `totalDone` is high, otherwise 0 |
| totalDone | output | 1 | One-cycle pulse marking the burst total |

## Verification
The hardest case to reach from the ports is two bursts separated by a single idle cycle. The final adder then reads the first burst's lane outputs in the same cycle that lane 0 takes the second burst's first sample with a cleared feedback path. The earlier lane's result must also come from the held copy, not the live adder output. The stimulus sweeps burst lengths of both parities with gaps of one, two and three cycles, and drives changing garbage on `sampleIn` during every idle cycle. A reset is also dropped into a half-finished burst, and the next burst is checked for a clean total.

// File: rtl/interleaved_acc_pkg.sv
package interleaved_acc_pkg;

  // Result latency of every adder instance; the lane count follows from it.
  localparam int ADD_LAT   = 2;
  localparam int NUM_LANES = ADD_LAT;

  typedef struct packed {
    logic [NUM_LANES-1:0] laneLoad;   // lane takes the current sample
    logic [NUM_LANES-1:0] laneClear;  // lane starts its partial sum from zero
    logic                 combine;    // final adder reads the partial sums
    logic                 lastOdd;    // last burst sample went to lane 1
    logic                 oddEmpty;   // lane 1 received no sample this burst
  } accStrobes_t;

endpackage

// File: rtl/lat2_adder.sv
module lat2_adder #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] sumOut
);

  logic [W-1:0] stageSum;
  logic [W-1:0] opSum;

  assign opSum = opA + opB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageSum <= '0;
      sumOut   <= '0;
    end else begin
      stageSum <= opSum;
      sumOut   <= stageSum;
    end
  end

  // Counts edges since reset so the latency check never looks into reset time.
  logic [1:0] warmCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              warmCnt <= '0;
    else if (warmCnt != 2'd2) warmCnt <= warmCnt + 2'd1;
  end

  assert_two_cycle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (warmCnt == 2'd2) |-> (sumOut == $past(opSum, 2)))
    else $error("adder latency is not two cycles");

endmodule

// File: rtl/interleaved_acc_ctrl.sv
module interleaved_acc_ctrl
  import interleaved_acc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleValid,
  output accStrobes_t stb,
  output logic        totalDone
);

  logic prevValid;
  logic parityReg;   // lane of the most recent accepted sample
  logic prevFirst;   // previous cycle held a burst's first sample
  logic combineReg;
  logic lastOddReg;
  logic oddEmptyReg;
  logic [ADD_LAT-1:0] donePipe;

  logic isFirst;
  logic parityNow;
  logic burstEnd;

  assign isFirst   = sampleValid && !prevValid;
  assign parityNow = isFirst ? 1'b0 : !parityReg;
  assign burstEnd  = !sampleValid && prevValid;

  always_comb begin
    stb              = '0;
    stb.laneLoad[0]  = sampleValid && !parityNow;
    stb.laneLoad[1]  = sampleValid && parityNow;
    stb.laneClear[0] = isFirst;
    stb.laneClear[1] = sampleValid && prevFirst;
    stb.combine      = combineReg;
    stb.lastOdd      = lastOddReg;
    stb.oddEmpty     = oddEmptyReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevValid   <= 1'b0;
      parityReg   <= 1'b0;
      prevFirst   <= 1'b0;
      combineReg  <= 1'b0;
      lastOddReg  <= 1'b0;
      oddEmptyReg <= 1'b0;
      donePipe    <= '0;
    end else begin
      prevValid  <= sampleValid;
      prevFirst  <= isFirst;
      combineReg <= burstEnd;
      donePipe   <= {donePipe[ADD_LAT-2:0], combineReg};
      if (sampleValid) parityReg <= parityNow;
      if (burstEnd) begin
        lastOddReg  <= parityReg;
        oddEmptyReg <= prevFirst;
      end
    end
  end

  assign totalDone = donePipe[ADD_LAT-1];

  assert_lane_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb.laneLoad))
    else $error("both lanes loaded in one cycle");

  assert_first_even_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !$past(sampleValid)) |-> (stb.laneLoad[0] && stb.laneClear[0]))
    else $error("burst start not routed to cleared lane 0");

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    totalDone |=> !totalDone)
    else $error("done held longer than one cycle");

  assert_done_after_end_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sampleValid) |=> ##2 totalDone)
    else $error("done pulse missing after burst end");

endmodule

// File: rtl/interleaved_acc_datapath.sv
module interleaved_acc_datapath
  import interleaved_acc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [W-1:0] sampleIn,
  input  accStrobes_t stb,
  output logic [W-1:0] totalOut
);

  logic [NUM_LANES-1:0][W-1:0] laneSum;
  logic [NUM_LANES-1:0][W-1:0] laneHold;

  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    logic [W-1:0] laneOpA;
    logic [W-1:0] laneOpB;

    assign laneOpA = stb.laneLoad[g] ? sampleIn : '0;
    assign laneOpB = (stb.laneLoad[g] && !stb.laneClear[g]) ? laneSum[g] : '0;

    lat2_adder #(.W(W)) u_laneAdder (
      .clk    (clk),
      .rstN   (rstN),
      .opA    (laneOpA),
      .opB    (laneOpB),
      .sumOut (laneSum[g])
    );

    // One-cycle copy lines up the lane that finished a cycle early.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) laneHold[g] <= '0;
      else       laneHold[g] <= laneSum[g];
    end
  end

  logic [W-1:0] liveSum;
  logic [W-1:0] heldSum;
  logic [W-1:0] finOpA;
  logic [W-1:0] finOpB;

  always_comb begin
    if (stb.lastOdd) begin
      liveSum = laneSum[1];
      heldSum = laneHold[0];
    end else begin
      liveSum = laneSum[0];
      heldSum = stb.oddEmpty ? '0 : laneHold[1];
    end
  end

  assign finOpA = stb.combine ? liveSum : '0;
  assign finOpB = stb.combine ? heldSum : '0;

  lat2_adder #(.W(W)) u_finalAdder (
    .clk    (clk),
    .rstN   (rstN),
    .opA    (finOpA),
    .opB    (finOpB),
    .sumOut (totalOut)
  );

endmodule

// File: rtl/interleaved_accumulator.sv
module interleaved_accumulator
  import interleaved_acc_pkg::*;
#(
  parameter int DATA_WIDTH = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [DATA_WIDTH-1:0] sampleIn,
  input  logic                  sampleValid,
  output logic [DATA_WIDTH-1:0] totalOut,
  output logic                  totalDone
);

  accStrobes_t stb;

  interleaved_acc_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .stb         (stb),
    .totalDone   (totalDone)
  );

  interleaved_acc_datapath #(.W(DATA_WIDTH)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .sampleIn (sampleIn),
    .stb      (stb),
    .totalOut (totalOut)
  );

  assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    !totalDone |-> (totalOut == '0))
    else $error("total visible without done");

endmodule

// File: tb/interleaved_accumulator_bench.sv
`timescale 1ns/1ps
module interleaved_accumulator_bench;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] sampleIn = '0;
  logic         sampleValid = 1'b0;
  logic [W-1:0] totalOut;
  logic         totalDone;

  always #2.5 clk = ~clk;

  interleaved_accumulator #(.DATA_WIDTH(W)) u_interleaved_accumulator (
    .clk         (clk),
    .rstN        (rstN),
    .sampleIn    (sampleIn),
    .sampleValid (sampleValid),
    .totalOut    (totalOut),
    .totalDone   (totalDone)
  );

  int checkCnt = 0;
  int failCnt  = 0;
  int posCnt   = 0;
  int garbage  = 17;
  string idleReq = "R3";

  int           expAt[$];
  logic [W-1:0] expVal[$];
  string        expReq[$];

  task automatic check(input string req, input string what, input int act, input int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Output monitor: every cycle is compared against the expected schedule.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rstN) begin
        if (expAt.size() > 0 && expAt[0] == posCnt) begin
          check(expReq[0], "done pulse", int'(totalDone), 1);
          check(expReq[0], "burst total", int'(totalOut), int'(expVal[0]));
          void'(expAt.pop_front());
          void'(expVal.pop_front());
          void'(expReq.pop_front());
        end else begin
          check(idleReq, "no done outside pulse", int'(totalDone), 0);
          check("R4", "total zero while idle", int'(totalOut), 0);
        end
      end
      posCnt++;
    end
  end

  function automatic logic [W-1:0] sampleOf(input int mode, input int seed, input int i);
    case (mode)
      0: return W'(i + 1);
      1: return W'(8'hFF);
      2: return (i == 0) ? W'(8'hFF) : W'(8'h02);
      3: return W'(seed);
      default: return W'(i * 37 + seed * 13 + (i * i) * 5);
    endcase
  endfunction

  // Drives one burst then an idle gap with garbage data (R8).
  task automatic runBurst(input int n, input int mode, input int seed, input int gap,
                          input string req);
    logic [W-1:0] acc = '0;
    for (int i = 0; i < n; i++) acc = acc + sampleOf(mode, seed, i);
    @(negedge clk);
    expAt.push_back(posCnt + n + 2);
    expVal.push_back(acc);
    expReq.push_back(req);
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      sampleValid = 1'b1;
      sampleIn    = sampleOf(mode, seed, i);
    end
    for (int k = 0; k < gap; k++) begin
      @(negedge clk);
      sampleValid = 1'b0;
      garbage     = garbage * 29 + 7;
      sampleIn    = W'(garbage);
    end
  endtask

  task automatic drain();
    for (int k = 0; k < 6; k++) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R1", "done in reset", int'(totalDone), 0);
    check("R1", "total in reset", int'(totalOut), 0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "done after release", int'(totalDone), 0);
    check("R1", "total after release", int'(totalOut), 0);

    // R5: single-sample bursts, back to back with one idle cycle
    for (int v = 0; v < 256; v += 15) runBurst(1, 3, v, 1, "R5");
    runBurst(1, 3, 255, 2, "R5");
    drain();

    // R2 and R8: length sweep with both parities and varied gaps
    for (int n = 2; n <= 24; n++)
      for (int s = 0; s < 3; s++)
        runBurst(n, 4, s + n, 1 + s, "R2");
    drain();

    // R6: back-to-back bursts, single idle cycle, mixed lengths
    for (int n = 1; n <= 12; n++) runBurst(n, 0, 0, 1, "R6");
    for (int n = 13; n >= 2; n--) runBurst(n, 4, n * 3, 1, "R6");
    drain();

    // R7: wrap-around
    runBurst(2, 2, 0, 1, "R7");
    runBurst(16, 1, 0, 1, "R7");
    runBurst(255, 1, 0, 2, "R7");
    drain();

    // R10: reset in the middle of a burst discards it
    @(negedge clk);
    sampleValid = 1'b1;
    sampleIn    = 8'h11;
    @(negedge clk);
    sampleIn    = 8'h22;
    @(negedge clk);
    sampleIn    = 8'h33;
    @(negedge clk);
    rstN        = 1'b0;
    sampleValid = 1'b0;
    sampleIn    = '0;
    repeat (2) @(posedge clk);
    #1;
    check("R10", "done during mid-burst reset", int'(totalDone), 0);
    check("R10", "total during mid-burst reset", int'(totalOut), 0);
    @(negedge clk);
    rstN    = 1'b1;
    idleReq = "R10";
    repeat (6) @(negedge clk);
    idleReq = "R3";
    runBurst(7, 4, 5, 1, "R10");
    runBurst(6, 0, 0, 1, "R10");
    drain();
    drain();
    check("R3", "all expected pulses seen", expAt.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checkCnt, failCnt);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    failCnt++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checkCnt, failCnt);
    $finish;
  end

endmodule